// File: doc/BRIEF.md
# Horizontal-Blank Chunked Video-Memory Copier

This block copies a programmed region of memory into video memory a little at a time. It moves one fixed chunk of 16 bytes each time the display reports a horizontal blanking event, so the copy is spread across many scanlines. Software first loads a source start address, a target start address, a byte count and a mode bit. After that, every blanking event on a visible scanline moves the next chunk until the count runs out.

While a chunk is moving, the block reads one byte per cycle through its read port. It writes the same byte to the target address in the same cycle, and both addresses step by one after each byte. For every chunk it raises a stall output towards the processor. The stall lasts 8 clocks at normal speed and 16 clocks when the speed-double flag is set.

The controller has two states. In `ST_IDLE` it accepts configuration loads and blanking events. In `ST_MOVE` it copies the bytes of one chunk. The transition `ST_IDLE -> ST_MOVE` ("chunk start") fires on an accepted blanking event. The transition `ST_MOVE -> ST_IDLE` ("chunk done") fires on the cycle that moves the last byte of the chunk. A configuration load keeps the block in `ST_IDLE`.

Top module: `hblank_chunk_dma`

## Requirements
- R1: After reset the block is in `ST_IDLE`. `busy`, `wr_en`, `rd_en` and `stall` are low, `remaining` is 0, and the mode is off.
- R2: A `cfg_load` pulse in `ST_IDLE` loads the source address, target address, length and mode, and `remaining` shows the new length on the next cycle. A `cfg_load` during `ST_MOVE` has no effect.
- R3: A blanking event starts a chunk only if all of these hold in the same cycle: the mode bit is 1, `remaining` is nonzero, `line` is below 144, and the block is in `ST_IDLE` with no `cfg_load` that cycle. `busy` rises on the next cycle.
- R4: A chunk asserts `busy`, `rd_en` and `wr_en` for exactly 16 consecutive cycles. Each of those cycles moves one byte.
- R5: During a chunk, `rd_addr` and `wr_addr` increase by one after each byte. `wr_data` equals the `rd_data` returned in the same cycle. Addresses carry on from where the previous chunk stopped.
- R6: When a chunk completes, `remaining` drops by 16, saturating at 0. It stays constant while the chunk runs.
- R7: `stall` goes high in the first cycle of a chunk. It stays high for 8 cycles when `speed_dbl` was 0 at the start event, and for 16 cycles when it was 1.
- R8: A blanking event that arrives while a chunk is moving is ignored, and the chunk still moves exactly 16 bytes.
- R9: While `remaining` is 0, blanking events are ignored until a new length is loaded.
- R10: With the mode bit set to 0, blanking events never start a chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load configuration pulse |
| cfg_src | input | 16 | Source start address |
| cfg_dst | input | 16 | Target start address |
| cfg_len | input | 16 | Byte count to move |
| cfg_hbl_mode | input | 1 | 1 = move on blanking events |
| hblank | input | 1 | Horizontal blanking event pulse |
| line | input | 8 | Current scanline number |
| speed_dbl | input | 1 | Double-speed flag, doubles stall cost |
| rd_addr | output | 16 | Read address |
| rd_en | output | 1 | Read enable |
| rd_data | input | 8 | Read data, valid in the same cycle |
| wr_en | output | 1 | Write enable |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| busy | output | 1 | Chunk in progress |
| stall | output | 1 | Processor stall request |
| remaining | output | 16 | Bytes left to move |

## Verification
The checker watches several rules on every cycle:
- a chunk only starts after a blanking event on a visible line with a nonzero count;
- both addresses step by one per busy cycle;
- `remaining` holds still during a chunk and drops by 16, saturating, when it ends;
- `stall` is up on the first chunk cycle;
- an exhausted count never starts a chunk.

Some behaviour needs whole scenarios, which only the bench's reference model can show: the exact 16-byte chunk length, the 8- versus 16-cycle stall window, and the ignored configuration load and blanking event during a chunk. The model compares all outputs on every clock across these scenarios.

// File: rtl/hbdma_pkg.sv
package hbdma_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } hbdma_state_t;

endpackage

// File: rtl/hbdma_addr_ctr.sv
module hbdma_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/hbdma_stall_timer.sv
module hbdma_stall_timer #(
    parameter int BASE_COST = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic dbl,
    output logic stall
);

    localparam int COST_W = $clog2(2 * BASE_COST + 1);

    logic [COST_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= dbl ? COST_W'(2 * BASE_COST) : COST_W'(BASE_COST);
        end else if (left_q != '0) begin
            left_q <= left_q - COST_W'(1);
        end
    end

    assign stall = (left_q != '0);

endmodule

// File: rtl/hblank_chunk_dma.sv
module hblank_chunk_dma
    import hbdma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int LINE_W    = 8,
    parameter int DATA_W    = 8,
    parameter int CHUNK     = 16,
    parameter int VISIBLE   = 144,
    parameter int BASE_COST = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_hbl_mode,
    input  logic              hblank,
    input  logic [LINE_W-1:0] line,
    input  logic              speed_dbl,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              stall,
    output logic [LEN_W-1:0]  remaining
);

    localparam int CNT_W = $clog2(CHUNK);

    hbdma_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] rem_q;
    logic             mode_q;
    logic             in_move, load_ok, accept, last_byte;

    assign in_move   = (state_q == ST_MOVE);
    assign load_ok   = (state_q == ST_IDLE) && cfg_load;
    assign accept    = (state_q == ST_IDLE) && !cfg_load && hblank && mode_q
                       && (rem_q != '0) && (line < LINE_W'(VISIBLE));
    assign last_byte = in_move && (cnt_q == CNT_W'(CHUNK - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: chunk start / chunk done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_MOVE;
            ST_MOVE: if (last_byte) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MOVE: begin
                busy  = 1'b1;
                wr_en = 1'b1;
                rd_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign wr_data   = rd_data;
    assign remaining = rem_q;

    // byte index inside the chunk
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
        end else if (in_move) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // length and mode
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            mode_q <= 1'b0;
        end else if (load_ok) begin
            rem_q  <= cfg_len;
            mode_q <= cfg_hbl_mode;
        end else if (last_byte) begin
            rem_q  <= (rem_q >= LEN_W'(CHUNK)) ? rem_q - LEN_W'(CHUNK) : '0;
        end
    end

    hbdma_addr_ctr #(.ADDR_W(ADDR_W)) u_src_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (cfg_src),
        .step     (in_move),
        .q        (rd_addr)
    );

    hbdma_addr_ctr #(.ADDR_W(ADDR_W)) u_dst_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (cfg_dst),
        .step     (in_move),
        .q        (wr_addr)
    );

    hbdma_stall_timer #(.BASE_COST(BASE_COST)) u_stall (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .dbl   (speed_dbl),
        .stall (stall)
    );

endmodule

// File: rtl/hbdma_checker.sv
module hbdma_checker #(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int LINE_W  = 8,
    parameter int CHUNK   = 16,
    parameter int VISIBLE = 144
) (
    input logic              clk,
    input logic              rst,
    input logic              hblank,
    input logic [LINE_W-1:0] line,
    input logic              busy,
    input logic              stall,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [LEN_W-1:0]  remaining
);

    p_start_cond_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(hblank) && ($past(line) < LINE_W'(VISIBLE))
                         && ($past(remaining) != '0)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((wr_addr == ADDR_W'($past(wr_addr) + 1'b1))
                                   && (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))));

    p_rem_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(remaining));

    p_rem_step_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (remaining == (($past(remaining) >= LEN_W'(CHUNK))
                                       ? LEN_W'($past(remaining) - LEN_W'(CHUNK)) : '0)));

    p_stall_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> stall);

    p_zero_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && (remaining == '0)) |=> !busy);

endmodule

bind hblank_chunk_dma hbdma_checker #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .LINE_W  (LINE_W),
    .CHUNK   (CHUNK),
    .VISIBLE (VISIBLE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hblank    (hblank),
    .line      (line),
    .busy      (busy),
    .stall     (stall),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .remaining (remaining)
);

// File: tb/hblank_chunk_dma_bench.sv
`timescale 1ns/1ps
module hblank_chunk_dma_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_len = '0;
    logic        cfg_hbl_mode = 1'b0;
    logic        hblank = 1'b0;
    logic [7:0]  line = '0;
    logic        speed_dbl = 1'b0;
    logic [15:0] rd_addr, wr_addr, remaining;
    logic [7:0]  rd_data, wr_data;
    logic        rd_en, wr_en, busy, stall;

    int total = 0;
    int bad = 0;
    int nwr = 0;
    int cycles = 0;

    // reference model state
    bit       m_busy = 0, m_mode = 0;
    int       m_cnt = 0, m_stall = 0;
    int       m_src = 0, m_dst = 0, m_rem = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign rd_data = mem_byte(rd_addr);

    hblank_chunk_dma u_hblank_chunk_dma (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_hbl_mode(cfg_hbl_mode),
        .hblank(hblank), .line(line), .speed_dbl(speed_dbl),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .stall(stall), .remaining(remaining)
    );

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_mode = 0; m_cnt = 0; m_stall = 0;
            m_src = 0; m_dst = 0; m_rem = 0;
        end else if (!m_busy) begin
            if (m_stall > 0) m_stall--;
            if (cfg_load) begin
                m_src = cfg_src; m_dst = cfg_dst; m_rem = cfg_len; m_mode = cfg_hbl_mode;
            end else if (hblank && m_mode && m_rem != 0 && line < 144) begin
                m_busy = 1; m_cnt = 0;
                m_stall = speed_dbl ? 16 : 8;
            end
        end else begin
            if (m_stall > 0) m_stall--;
            m_src = (m_src + 1) & 16'hFFFF;
            m_dst = (m_dst + 1) & 16'hFFFF;
            if (m_cnt == 15) begin
                m_busy = 0;
                m_rem = (m_rem >= 16) ? m_rem - 16 : 0;
            end
            m_cnt++;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy, m_busy, "R4 busy");
            chk(wr_en, m_busy, "R4 wr_en");
            chk(rd_en, m_busy, "R4 rd_en");
            chk(rd_addr, m_src, "R5 rd_addr");
            chk(wr_addr, m_dst, "R5 wr_addr");
            chk(wr_data, mem_byte(16'(m_src)), "R5 wr_data");
            chk(stall, (m_stall != 0), "R7 stall");
            chk(remaining, m_rem, "R6 remaining");
            if (wr_en) nwr++;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input int s, input int d, input int l, input bit m);
        cfg_src = 16'(s); cfg_dst = 16'(d); cfg_len = 16'(l); cfg_hbl_mode = m;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic hb(input int l);
        hblank = 1'b1; line = 8'(l);
        @(negedge clk);
        hblank = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        @(negedge clk);
        chk(busy, 0, "R1 busy");
        chk(wr_en, 0, "R1 wr_en");
        chk(stall, 0, "R1 stall");
        chk(remaining, 0, "R1 remaining");

        load(16'h1000, 16'h8000, 40, 1'b1);
        chk(remaining, 40, "R2 load");

        speed_dbl = 1'b0;
        nwr = 0;
        hb(10);
        chk(busy, 1, "R3 start");
        wait_n(2);
        hb(20);
        wait_n(20);
        chk(nwr, 16, "R8 extra event ignored");
        chk(remaining, 24, "R6 first chunk");

        speed_dbl = 1'b1;
        hb(50);
        chk(busy, 1, "R3 second start");
        speed_dbl = 1'b0;
        wait_n(20);
        chk(remaining, 8, "R6 second chunk");
        chk(rd_addr, 16'h1020, "R5 address carry");

        hb(100);
        wait_n(20);
        chk(remaining, 0, "R6 saturate");

        nwr = 0;
        hb(101);
        chk(busy, 0, "R9 zero length");
        wait_n(3);
        chk(nwr, 0, "R9 no writes");

        load(16'h2000, 16'h9000, 32, 1'b0);
        hb(5);
        chk(busy, 0, "R10 mode off");

        load(16'h3000, 16'hA000, 32, 1'b1);
        hb(144);
        chk(busy, 0, "R3 line limit");
        hb(143);
        chk(busy, 1, "R3 last visible line");
        load(16'h4444, 16'h5555, 100, 1'b1);
        wait_n(20);
        chk(remaining, 16, "R2 load ignored while busy");
        chk(rd_addr, 16'h3010, "R2 source kept");

        finish_run();
    end

    initial begin
        wait (cycles > 5000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

endmodule